// File: doc/BRIEF.md
# Input-Queued Switch Crossbar Matcher

This block picks a set of conflict-free connections for an input-queued crossbar switch that keeps one queue per (input, output) pair. Each cell time, the switch gives it a square matrix of occupancy bits. Bit `i*N + j` of `req_matrix` is set when input `i` holds a cell for output `j`. The block runs iterative request/grant/accept matching. Every output keeps a rotating grant pointer and every input keeps a rotating accept pointer. The block returns a match matrix, in the same layout, that has at most one bit set in any row and in any column.

A request matrix comes in through a valid/ready handshake. The block takes a matrix only while `req_ready` is high. `req_ready` then stays low while the matching iterations run, one per clock, and the block ignores `req_valid` during that time. The result leaves as a one-cycle `match_valid` pulse. The result side has no back-pressure. The result stays on `match_matrix` until the next matrix is taken, so a consumer can sample it late. Pointers move only for connections made in the first iteration. Each pointer moves to one place past the partner it was connected to, which gives the most recent connection the lowest priority next time. Later iterations only fill ports that are still free.

Top module: `voq_match_sched`

## Requirements
- R1: `req_ready` is high whenever no matching is in progress. A matrix is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is then low for exactly ITERS cycles, and the block ignores `req_valid` and `req_matrix` during those cycles.
- R2: `match_valid` is high for exactly one cycle. It rises ITERS clock edges after the edge that took the matrix. `match_matrix` keeps its value from then until the next matrix is taken.
- R3: A match bit is set only where the taken request bit is set (bit `i*N+j` = input i to output j). No row and no column of the match holds more than one set bit.
- R4: An output that sees requests from free inputs grants the first such input found when scanning upward from its grant pointer, wrapping past N-1 to 0.
- R5: An input that receives grants accepts the first granting output found when scanning upward from its accept pointer, wrapping past N-1 to 0.
- R6: When input i and output j are connected in the first iteration, the grant pointer of output j becomes (i+1) mod N and the accept pointer of input i becomes (j+1) mod N.
- R7: Connections made in the second and later iterations leave all pointers unchanged.
- R8: Inputs and outputs matched in an earlier iteration take no part in later iterations of the same cell time. Each later iteration adds matches among the ports that are still free.
- R9: After reset, all pointers are 0, the match matrix is all zero, `match_valid` is low and `req_ready` is high.
- R10: An input that keeps requesting the same output is matched to it within N*N cell times.
- R11: An all-zero request matrix produces an all-zero match and leaves the pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request matrix is offered |
| req_ready | output | 1 | Block is idle and takes an offered matrix |
| req_matrix | input | N*N | Occupancy bits, bit i*N+j = input i has a cell for output j |
| match_valid | output | 1 | One-cycle pulse: match_matrix holds a new result |
| match_matrix | output | N*N | Chosen connections, same bit layout as req_matrix |

## Verification
The assertions assume only that `req_valid` and `req_matrix` are known values after reset. They make no assumption about `req_valid` while the block is busy, because the block must ignore it then. The bench drives `req_valid` high with junk matrices during busy cycles on purpose, and drops it before the block can take another matrix. The bench drives inputs on falling edges, so every value is settled at the rising edge. A reference model of the pointer rules, running beside the design, provides the expected results for long runs of pseudo-random matrices. Hand-worked results pin down the first cells after reset.

// File: rtl/voqm_pkg.sv
package voqm_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_ITER = 1'b1
  } phase_e;
endpackage

// File: rtl/rr_pick.sv
// Programmable priority pick: rotate requests so the pointer sits at bit 0,
// isolate the lowest set bit, rotate the one-hot result back.
module rr_pick #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic [N-1:0]  pick
);
  logic [2*N-1:0] dbl_req;
  logic [N-1:0]   rot_req;
  logic [N-1:0]   rot_pick;
  logic [2*N-1:0] dbl_pick;

  assign dbl_req  = {req, req} >> ptr;
  assign rot_req  = dbl_req[N-1:0];
  assign rot_pick = rot_req & (~rot_req + {{(N-1){1'b0}}, 1'b1});
  assign dbl_pick = {rot_pick, rot_pick} << ptr;
  assign pick     = dbl_pick[2*N-1:N];

  always_comb begin
    assert_pick_subset_R4: assert ((pick & ~req) == '0);
    assert_pick_onehot_R4: assert ($onehot0(pick));
  end
endmodule

// File: rtl/grant_stage.sv
// One round robin picker per output, scanning the inputs of its column.
module grant_stage #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N*N-1:0]  req_flat,
  input  logic [N-1:0]    row_free,
  input  logic [N-1:0]    col_free,
  input  logic [N*PW-1:0] gptr_flat,
  output logic [N*N-1:0]  grant_flat
);
  for (genvar gj = 0; gj < N; gj++) begin : g_out
    logic [N-1:0] col_req;
    logic [N-1:0] col_pick;
    for (genvar gi = 0; gi < N; gi++) begin : g_in
      assign col_req[gi] = req_flat[gi*N+gj] & row_free[gi] & col_free[gj];
      assign grant_flat[gi*N+gj] = col_pick[gi];
    end
    rr_pick #(.N(N), .PW(PW)) u_pick (
      .req  (col_req),
      .ptr  (gptr_flat[gj*PW +: PW]),
      .pick (col_pick)
    );
    always_comb begin
      assert_grant_freecol_R8: assert (col_free[gj] || (col_pick == '0));
    end
  end
endmodule

// File: rtl/accept_stage.sv
// One round robin picker per input, scanning the grants it received.
module accept_stage #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N*N-1:0]  grant_flat,
  input  logic [N*PW-1:0] aptr_flat,
  output logic [N*N-1:0]  accept_flat
);
  for (genvar gi = 0; gi < N; gi++) begin : g_in
    logic [N-1:0] row_pick;
    rr_pick #(.N(N), .PW(PW)) u_pick (
      .req  (grant_flat[gi*N +: N]),
      .ptr  (aptr_flat[gi*PW +: PW]),
      .pick (row_pick)
    );
    assign accept_flat[gi*N +: N] = row_pick;
  end
endmodule

// File: rtl/voq_match_sched.sv
module voq_match_sched #(
  parameter int N     = 4,
  parameter int ITERS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [N*N-1:0]   req_matrix,
  output logic             match_valid,
  output logic [N*N-1:0]   match_matrix
);
  import voqm_pkg::*;

  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam int IW = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [IW-1:0] LAST_IT = IW'(ITERS - 1);

  phase_e          phase_q;
  logic [IW-1:0]   iter_q;
  logic [N*N-1:0]  reqm_q;
  logic [N*N-1:0]  match_q;
  logic            done_q;
  logic [PW-1:0]   gptr_q [N];
  logic [PW-1:0]   aptr_q [N];

  logic [N*PW-1:0] gptr_flat;
  logic [N*PW-1:0] aptr_flat;
  logic [N-1:0]    row_free;
  logic [N-1:0]    col_free;
  logic [N*N-1:0]  grant_w;
  logic [N*N-1:0]  accept_w;
  logic            busy;
  logic            take;

  assign busy = (phase_q == PH_ITER);
  assign take = req_valid && !busy;

  for (genvar gk = 0; gk < N; gk++) begin : g_port
    logic [N-1:0] col_bits;
    for (genvar gm = 0; gm < N; gm++) begin : g_col
      assign col_bits[gm] = match_q[gm*N+gk];
    end
    assign row_free[gk] = ~|match_q[gk*N +: N];
    assign col_free[gk] = ~|col_bits;
    assign gptr_flat[gk*PW +: PW] = gptr_q[gk];
    assign aptr_flat[gk*PW +: PW] = aptr_q[gk];
  end

  grant_stage #(.N(N), .PW(PW)) u_grant (
    .req_flat   (reqm_q),
    .row_free   (row_free),
    .col_free   (col_free),
    .gptr_flat  (gptr_flat),
    .grant_flat (grant_w)
  );

  accept_stage #(.N(N), .PW(PW)) u_accept (
    .grant_flat  (grant_w),
    .aptr_flat   (aptr_flat),
    .accept_flat (accept_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      iter_q  <= '0;
      reqm_q  <= '0;
      match_q <= '0;
      done_q  <= 1'b0;
      for (int k = 0; k < N; k++) begin
        gptr_q[k] <= '0;
        aptr_q[k] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          reqm_q  <= req_matrix;
          match_q <= '0;
          iter_q  <= '0;
          phase_q <= PH_ITER;
        end
      end else begin
        match_q <= match_q | accept_w;
        if (iter_q == LAST_IT) begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end else begin
          iter_q <= iter_q + 1'b1;
        end
        if (iter_q == '0) begin
          for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
              if (accept_w[i*N+j]) begin
                gptr_q[j] <= PW'((i + 1) % N);
                aptr_q[i] <= PW'((j + 1) % N);
              end
            end
          end
        end
      end
    end
  end

  assign req_ready    = !busy;
  assign match_valid  = done_q;
  assign match_matrix = match_q;

  // Handshake and result timing
  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_ready);
  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |=> !match_valid);
  assert_result_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> $stable(match_matrix));
  assert_match_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> ((match_matrix & ~reqm_q) == '0));
  assert_match_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (($past(match_q) & ~match_q) == '0));
  assert_late_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && iter_q != '0) |=> ($stable(gptr_flat) && $stable(aptr_flat)));
  assert_idle_ptr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(gptr_flat) && $stable(aptr_flat)));

  for (genvar ga = 0; ga < N; ga++) begin : g_chk
    logic [N-1:0] col_m;
    for (genvar gb = 0; gb < N; gb++) begin : g_bit
      assign col_m[gb] = match_matrix[gb*N+ga];
      assert_gptr_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && iter_q == '0 && accept_w[gb*N+ga])
          |=> (gptr_q[ga] == PW'((gb + 1) % N)));
      assert_aptr_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && iter_q == '0 && accept_w[ga*N+gb])
          |=> (aptr_q[ga] == PW'((gb + 1) % N)));
    end
    assert_row_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_matrix[ga*N +: N]));
    assert_col_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col_m));
  end
endmodule

// File: tb/voq_match_sched_bench.sv
`timescale 1ns/1ps
module voq_match_sched_bench;
  localparam int N     = 4;
  localparam int ITERS = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [N*N-1:0]  req_matrix = '0;
  logic            match_valid;
  logic [N*N-1:0]  match_matrix;

  int checks = 0;
  int errors = 0;
  int gp [N];
  int ap [N];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  voq_match_sched #(.N(N), .ITERS(ITERS)) u_voq_match_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_matrix   (req_matrix),
    .match_valid  (match_valid),
    .match_matrix (match_matrix)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference of the matching rules, kept apart from the design.
  task automatic model_cell(input logic [N*N-1:0] r, output logic [N*N-1:0] m);
    logic [N*N-1:0] g;
    logic [N*N-1:0] a;
    m = '0;
    for (int it = 0; it < ITERS; it++) begin
      bit rf [N];
      bit cf [N];
      for (int p = 0; p < N; p++) begin
        rf[p] = 1'b1;
        cf[p] = 1'b1;
      end
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (m[i*N+j]) begin rf[i] = 1'b0; cf[j] = 1'b0; end
      g = '0;
      for (int j = 0; j < N; j++) begin
        bit found = 1'b0;
        for (int k = 0; k < N; k++) begin
          int i = (gp[j] + k) % N;
          if (!found && cf[j] && rf[i] && r[i*N+j]) begin
            g[i*N+j] = 1'b1;
            found = 1'b1;
          end
        end
      end
      a = '0;
      for (int i = 0; i < N; i++) begin
        bit found = 1'b0;
        for (int k = 0; k < N; k++) begin
          int j = (ap[i] + k) % N;
          if (!found && g[i*N+j]) begin
            a[i*N+j] = 1'b1;
            found = 1'b1;
          end
        end
      end
      if (it == 0)
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++)
            if (a[i*N+j]) begin gp[j] = (i + 1) % N; ap[i] = (j + 1) % N; end
      m = m | a;
    end
  endtask

  function automatic bit conflict_free(input logic [N*N-1:0] m);
    for (int p = 0; p < N; p++) begin
      int rc = 0;
      int cc = 0;
      for (int q = 0; q < N; q++) begin
        rc += int'(m[p*N+q]);
        cc += int'(m[q*N+p]);
      end
      if (rc > 1 || cc > 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  // Offers one matrix, optionally pokes junk while busy, checks timing and result.
  task automatic run_cell(input logic [N*N-1:0] r, input bit junk, output logic [N*N-1:0] got);
    logic [N*N-1:0] exp_m;
    model_cell(r, exp_m);
    @(negedge clk);
    chk("R1 ready before offer", 32'(req_ready), 32'd1);
    req_matrix = r;
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid = junk;
    req_matrix = junk ? ~r : '0;
    for (int c = 0; c < ITERS; c++) begin
      if (c == ITERS - 1) req_valid = 1'b0;
      chk("R1 ready low while busy", 32'(req_ready), 32'd0);
      chk("R2 no early valid", 32'(match_valid), 32'd0);
      if (c < ITERS - 1) @(negedge clk);
    end
    @(negedge clk);
    chk("R2 valid pulse", 32'(match_valid), 32'd1);
    chk("R1 ready after result", 32'(req_ready), 32'd1);
    got = match_matrix;
    chk("R3 subset of requests", 32'(got & ~r), 32'd0);
    chk("R3 one per row and column", 32'(conflict_free(got)), 32'd1);
    chk("R4 R5 R8 match vs model", 32'(got), 32'(exp_m));
    @(negedge clk);
    chk("R2 pulse ends", 32'(match_valid), 32'd0);
    chk("R2 result held", 32'(match_matrix), 32'(got));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 ready after reset", 32'(req_ready), 32'd1);
    chk("R9 valid low after reset", 32'(match_valid), 32'd0);
    chk("R9 match cleared", 32'(match_matrix), 32'd0);
  endtask

  // From zero pointers, an all-ones matrix matches the diagonal 0..2.
  task automatic t_full_first();
    logic [N*N-1:0] got;
    run_cell('1, 1'b0, got);
    chk("R9 R4 R5 zero-pointer full match", 32'(got), 32'h0421);
  endtask

  // Only first-iteration pairs (0,0) moved pointers, so the next full cell
  // gives (0,1),(1,0),(2,2),(3,3); busy-time junk must not matter.
  task automatic t_full_second();
    logic [N*N-1:0] got;
    run_cell('1, 1'b1, got);
    chk("R6 R7 R1 second full match", 32'(got), 32'h8412);
  endtask

  task automatic t_empty();
    logic [N*N-1:0] got;
    logic [N*N-1:0] again;
    run_cell('0, 1'b0, got);
    chk("R11 empty match", 32'(got), 32'd0);
    run_cell('1, 1'b0, again);
    chk("R11 pointers kept across empty cell", 32'(conflict_free(again)), 32'd1);
  endtask

  // A later iteration fills ports left free: inputs 0 and 1 both want output 0,
  // input 1 also wants output 1.
  task automatic t_fill();
    logic [N*N-1:0] got;
    run_cell(16'h0031, 1'b0, got);
    chk("R8 two connections found", 32'($countones(got)), 32'd2);
  endtask

  task automatic t_starve();
    logic [N*N-1:0] got;
    int waited = 0;
    bit served = 1'b0;
    for (int c = 0; c < N*N && !served; c++) begin
      run_cell(16'h1111, 1'b0, got);
      waited++;
      if (got[3*N+0]) served = 1'b1;
    end
    chk("R10 input 3 served within N*N cells", 32'(served), 32'd1);
    chk("R10 wait bound", 32'(waited <= N*N), 32'd1);
  endtask

  task automatic t_random();
    logic [N*N-1:0] got;
    for (int c = 0; c < 60; c++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run_cell(lfsr[15:0] & lfsr[31:16] | lfsr[23:8], c[0], got);
    end
  endtask

  bit finished = 1'b0;

  initial begin
    for (int k = 0; k < N; k++) begin gp[k] = 0; ap[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_first();
    t_full_second();
    t_empty();
    t_fill();
    t_starve();
    t_random();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule